// File: doc/BRIEF.md
# Three-Wire Serial Master Transceiver

This block is a master on a clocked three-wire serial link with a clock line, a data-out line and a data-in line. Each transfer is full-duplex. The word that goes out and the word that comes in share one shift register. On every bit boundary the register moves one place. The outgoing bit leaves at one end and the sampled incoming bit enters at the other end.

Software drives a set of plain control pins to configure the block. These pins cover the power gate, the transmit, receive and interrupt enables, the bit order, the clock polarity and phase, and a length code. Configuration is normally done while power is off. Power is then raised. A transfer starts when a word is accepted on the valid/ready transmit port.

The transmit port applies back-pressure. `tx_ready` is high only when power is on and no transfer is running. A word offered while `tx_ready` is low is not taken, and the source must keep offering it. The receive side has no back-pressure. The received word is held in `rx_data` until the next completed transfer, and a one-cycle `rx_done` pulse announces it. The serial clock runs at the system clock divided by 2·`HALF_DIV`.

Top module: `ser3w_master`

## Requirements
- R1: While `pwr_en` is 0, `tx_ready` is 0, no word is accepted and `busy` is 0 from the next cycle on. A running transfer is abandoned, `sck` returns to its idle level and `sdo` is 0.
- R2: A word is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1, and `busy` is 1 after that edge. `tx_ready` equals `pwr_en` AND NOT `busy`, so a word offered during a transfer is ignored and does not disturb it.
- R3: The word length is 8 + `len_code[2:0]` bits when `len_code[3]` is 0, and 16 bits when `len_code[3]` is 1. Each bit lasts 2·`HALF_DIV` clocks, so `busy` stays 1 for length·2·`HALF_DIV` cycles.
- R4: When `lsb_first`=0, bit length−1 of the word goes out first. Received bits enter at bit 0 as the register moves left. Sending 0x55 while receiving 0xAA over 8 bits passes the register through 0x55, 0xAB, 0x56, 0xAD, 0x5A, 0xB5, 0x6A, 0xD5 and 0xAA.
- R5: When `lsb_first`=1, bit 0 goes out first. Received bits enter at bit length−1 as the register moves right.
- R6: `sck` idles at NOT `clk_pol`. With `clk_pha`=0 it sits at the non-idle level in the first half of each bit time and at the idle level in the second half. `clk_pha`=1 swaps the two halves. `sdi` is sampled at the mid-bit transition, and `sdo` changes only at bit boundaries.
- R7: On the edge where `busy` falls, `rx_data` takes the received word with the unused upper bits at 0. `rx_done` is then 1 for exactly one cycle.
- R8: When `rx_en` is 0, a transfer leaves `rx_data` unchanged.
- R9: When `tx_en` is 0, `sdo` stays 0 for the whole transfer. `sdo` is also 0 whenever the block is not busy.
- R10: When `irq_en` is 0, no `rx_done` pulse occurs, but `busy` still falls and `rx_data` is still updated.
- R11: After reset, `busy`, `rx_done`, `rx_data` and `sdo` are 0 and `sck` is at its idle level.
- R12: In the cycle where `rx_done` is 1, `tx_ready` is already 1. A word offered in that cycle is accepted there, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power gate; 0 holds the block inactive |
| tx_en | input | 1 | Drive data onto `sdo` |
| rx_en | input | 1 | Store the received word |
| irq_en | input | 1 | Allow the `rx_done` pulse |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| clk_pol | input | 1 | Clock polarity; idle level is its inverse |
| clk_pha | input | 1 | Clock phase, selects which half of a bit is active |
| len_code | input | 4 | Word length code |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be accepted |
| tx_data | input | W | Transmit word |
| rx_data | output | W | Last received word |
| rx_done | output | 1 | One-cycle reception-complete pulse |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The completion pulse of one transfer and the acceptance of the next word can land in the same cycle. The bench provokes this on purpose by running the vector table back to back. Each new word is already offered on the clock edge that ends the previous transfer. In that cycle the bench checks that `rx_done` and `tx_ready` are both high. In the first cycle of the new transfer it checks that `busy` is set, `rx_done` has dropped and `rx_data` still holds the previous word.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

  localparam int NB_W = 5;

  typedef struct packed {
    logic            lsb_first;
    logic            cpha;
    logic            cpol;
    logic            tx_en;
    logic            rx_en;
    logic            irq_en;
    logic [NB_W-1:0] nbits;
  } ser_cfg_t;

  function automatic logic [NB_W-1:0] code_to_bits(input logic [3:0] code, input int min_len,
                                                   input int full_len);
    if (code[3]) return NB_W'(full_len);
    return NB_W'(min_len + int'(code[2:0]));
  endfunction

endpackage

// File: rtl/ser3w_tick.sv
module ser3w_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mid_stb,
  output logic end_stb,
  output logic second_half
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      half_q <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      half_q <= ~half_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mid_stb     = run && (cnt == LAST) && !half_q;
  assign end_stb     = run && (cnt == LAST) && half_q;
  assign second_half = half_q;
endmodule

// File: rtl/ser3w_shreg.sv
module ser3w_shreg #(
  parameter int W   = 16,
  parameter int NBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic           in_bit,
  input  logic           lsb_first,
  input  logic [NBW-1:0] nbits,
  input  logic [W-1:0]   load_val,
  output logic [W-1:0]   q,
  output logic [W-1:0]   shifted,
  output logic           out_bit
);
  logic [W-1:0] mask;
  logic [W-1:0] top_hot;

  // one bit per register position: inside the active length, and the top active slot
  for (genvar i = 0; i < W; i++) begin : g_pos
    assign mask[i]    = (i < int'(nbits));
    assign top_hot[i] = (i == int'(nbits) - 1);
  end

  always_comb begin
    if (lsb_first) shifted = ((q >> 1) & ~top_hot) | (top_hot & {W{in_bit}});
    else           shifted = ((q << 1) | W'(in_bit)) & mask;
  end

  assign out_bit = lsb_first ? q[0] : |(q & top_hot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val & mask;
    else if (shift) q <= shifted;
  end
endmodule

// File: rtl/ser3w_master.sv
module ser3w_master
  import ser3w_pkg::*;
#(
  parameter int W        = 16,
  parameter int HALF_DIV = 4,
  parameter int LEN_MIN  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_en,
  input  logic         tx_en,
  input  logic         rx_en,
  input  logic         irq_en,
  input  logic         lsb_first,
  input  logic         clk_pol,
  input  logic         clk_pha,
  input  logic [3:0]   len_code,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  output logic [W-1:0] rx_data,
  output logic         rx_done,
  output logic         busy,
  output logic         sck,
  output logic         sdo,
  input  logic         sdi
);
  ser_cfg_t     cfg_in, cfg_q, cfg_cur;
  logic [NB_W-1:0] bit_cnt;
  logic         accept, mid_stb, end_stb, second_half;
  logic         samp, last_bit;
  logic [W-1:0] sr_q, sr_next;
  logic         sr_out;

  always_comb begin
    cfg_in.lsb_first = lsb_first;
    cfg_in.cpha      = clk_pha;
    cfg_in.cpol      = clk_pol;
    cfg_in.tx_en     = tx_en;
    cfg_in.rx_en     = rx_en;
    cfg_in.irq_en    = irq_en;
    cfg_in.nbits     = code_to_bits(len_code, LEN_MIN, W);
  end

  assign tx_ready = pwr_en && !busy;
  assign accept   = tx_valid && tx_ready;
  assign cfg_cur  = busy ? cfg_q : cfg_in;
  assign last_bit = (bit_cnt == cfg_q.nbits - 1'b1);

  ser3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mid_stb(mid_stb), .end_stb(end_stb), .second_half(second_half)
  );

  ser3w_shreg #(.W(W), .NBW(NB_W)) u_sr (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .shift(busy && end_stb), .in_bit(samp),
    .lsb_first(cfg_cur.lsb_first), .nbits(cfg_cur.nbits),
    .load_val(tx_data), .q(sr_q), .shifted(sr_next), .out_bit(sr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cfg_q   <= '0;
      bit_cnt <= '0;
      samp    <= 1'b0;
      rx_data <= '0;
      rx_done <= 1'b0;
    end else if (!pwr_en) begin
      busy    <= 1'b0;
      rx_done <= 1'b0;
      bit_cnt <= '0;
    end else begin
      rx_done <= 1'b0;
      if (mid_stb) samp <= cfg_q.rx_en & sdi;
      if (accept) begin
        busy    <= 1'b1;
        cfg_q   <= cfg_in;
        bit_cnt <= '0;
      end else if (busy && end_stb) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) begin
          busy <= 1'b0;
          if (cfg_q.rx_en) rx_data <= sr_next;
          rx_done <= cfg_q.irq_en;
        end
      end
    end
  end

  always_comb begin
    if (!busy)                        sck = ~clk_pol;
    else if (second_half == cfg_q.cpha) sck = cfg_q.cpol;
    else                              sck = ~cfg_q.cpol;
  end

  assign sdo = busy && cfg_q.tx_en && sr_out;
endmodule

// File: rtl/ser3w_master_chk.sv
module ser3w_master_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_en,
  input logic         clk_pol,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         busy,
  input logic         rx_done,
  input logic [W-1:0] rx_data,
  input logic         sck,
  input logic         sdo
);
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (pwr_en && !busy));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid && tx_ready));

  p_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !busy);

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $fell(busy));

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rx_data));

  p_idle_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == !clk_pol));

  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo);
endmodule

bind ser3w_master ser3w_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .clk_pol(clk_pol),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .rx_done(rx_done),
  .rx_data(rx_data), .sck(sck), .sdo(sdo)
);

// File: tb/ser3w_master_test.sv
module ser3w_master_test;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int HD    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_en = 0, tx_en = 0, rx_en = 0, irq_en = 0, lsb_first = 0, clk_pol = 0, clk_pha = 0;
  logic [3:0] len_code = '0;
  logic tx_valid = 0, sdi = 0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_done, busy, sck, sdo;
  logic [W-1:0] rx_data;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_rx = '0;

  always #(CLK_P/2) clk = ~clk;

  ser3w_master #(.W(W), .HALF_DIV(HD), .LEN_MIN(8)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
    .irq_en(irq_en), .lsb_first(lsb_first), .clk_pol(clk_pol), .clk_pha(clk_pha),
    .len_code(len_code), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_data(rx_data), .rx_done(rx_done), .busy(busy), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {tx, slave word, len code, lsb_first, phase, polarity}
  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {16'h0055, 16'h00AA, 4'd0, 1'b0, 1'b0, 1'b0},
    {16'h25C3, 16'h3C5A, 4'd7, 1'b0, 1'b0, 1'b0},
    {16'h0155, 16'h00F0, 4'd1, 1'b1, 1'b0, 1'b0},
    {16'h1234, 16'h0ABC, 4'd4, 1'b0, 1'b1, 1'b0},
    {16'h80C3, 16'hE096, 4'd8, 1'b1, 1'b1, 1'b1},
    {16'hFFFF, 16'h0000, 4'd3, 1'b0, 1'b0, 1'b1}
  };

  task automatic run_xfer(input logic [15:0] tx, input logic [15:0] slave, input logic [3:0] code,
                          input logic lsb, input logic pha, input logic pol,
                          input logic en_tx, input logic en_rx, input logic en_irq,
                          input logic poke, input string tag);
    int L = code[3] ? 16 : 8 + int'(code[2:0]);
    logic [15:0] m = 16'((32'd1 << L) - 1);
    logic [15:0] got = '0;
    int sck_bad = 0;
    int pos;
    pwr_en = 1; tx_en = en_tx; rx_en = en_rx; irq_en = en_irq;
    lsb_first = lsb; clk_pha = pha; clk_pol = pol; len_code = code;
    tx_data = tx; tx_valid = 1;
    if (rx_done) chk(tx_ready == 1'b1, "R12 ready with done", 32'(tx_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    tx_valid = 0;
    for (int c = 0; c <= 2*HD*L; c++) begin
      if (c == 0) begin
        chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
        chk(rx_done == 1'b0 && rx_data == exp_rx, "R12 old word kept", 32'(rx_data), 32'(exp_rx));
      end
      if (c < 2*HD*L && c % (2*HD) == 0) begin
        pos = lsb ? c/(2*HD) : L-1-c/(2*HD);
        got[pos] = sdo;
        sdi = slave[pos];
        if (sck != (pha ? ~pol : pol)) sck_bad++;
      end
      if (c % (2*HD) == HD && sck != (pha ? pol : ~pol)) sck_bad++;
      if (poke && c == HD) begin
        chk(tx_ready == 1'b0, "R2 ready low while busy", 32'(tx_ready), 32'd0);
        tx_valid = 1; tx_data = ~tx;
      end
      if (poke && c == HD + 1) tx_valid = 0;
      if (c == 2*HD*L - 1) chk(busy == 1'b1, "R3 busy through last cycle", 32'(busy), 32'd1);
      if (c == 2*HD*L) begin
        if (en_rx) exp_rx = slave & m;
        chk(busy == 1'b0, "R3 busy cleared at end", 32'(busy), 32'd0);
        chk(rx_done == en_irq, en_irq ? "R7 done pulse" : "R10 no pulse", 32'(rx_done), 32'(en_irq));
        chk(rx_data == exp_rx, en_rx ? {tag, " received word"} : "R8 rx kept",
            32'(rx_data), 32'(exp_rx));
        chk(got == (en_tx ? (tx & m) : 16'h0), en_tx ? {tag, " sent word"} : "R9 sdo silent",
            32'(got), 32'(en_tx ? (tx & m) : 16'h0));
        chk(sck_bad == 0, "R6 clock levels", 32'(sck_bad), 32'd0);
      end
      if (c < 2*HD*L) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && rx_done == 0 && sdo == 0, "R11 flags after reset", {busy, rx_done, sdo}, 0);
    chk(rx_data == 0, "R11 rx_data after reset", 32'(rx_data), 0);
    chk(sck == 1'b1, "R11 sck idle", 32'(sck), 1);
    // R1 power off blocks acceptance
    tx_valid = 1; tx_data = 16'h00A5;
    chk(tx_ready == 0, "R1 ready low with power off", 32'(tx_ready), 0);
    @(negedge clk);
    chk(busy == 0, "R1 no start with power off", 32'(busy), 0);
    tx_valid = 0;

    // vector table, back to back: each start lands in the previous done cycle (R12)
    for (int v = 0; v < NV; v++) begin
      logic [38:0] e = VEC[v];
      run_xfer(e[38:23], e[22:7], e[6:3], e[2], e[1], e[0], 1, 1, 1, 0,
               e[6] ? "R3" : (e[2] ? "R5" : "R4"));
    end

    // directed corner cases
    run_xfer(16'h00C6, 16'h0033, 4'd0, 0, 0, 0, 1, 1, 1, 1, "R2");   // ignored offer mid-transfer
    run_xfer(16'h00FF, 16'h005A, 4'd0, 0, 0, 0, 0, 1, 1, 0, "R9");   // transmit disabled
    run_xfer(16'h0081, 16'h00E7, 4'd0, 1, 0, 0, 1, 0, 1, 0, "R8");   // receive disabled
    run_xfer(16'h0042, 16'h0099, 4'd2, 0, 1, 1, 1, 1, 0, 0, "R10");  // interrupt disabled
    @(negedge clk);

    // R1 abort: drop power mid-transfer
    pwr_en = 1; clk_pol = 1; tx_en = 1; rx_en = 1; irq_en = 1; len_code = 0;
    tx_data = 16'h00FF; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    repeat (5) @(negedge clk);
    pwr_en = 0;
    @(negedge clk);
    chk(busy == 0 && rx_done == 0, "R1 abort clears busy", {busy, rx_done}, 0);
    chk(sck == 1'b0 && sdo == 1'b0, "R1 abort idles lines", {sck, sdo}, 0);
    chk(rx_data == exp_rx, "R1 abort keeps rx_data", 32'(rx_data), 32'(exp_rx));
    clk_pol = 0;
    run_xfer(16'h0055, 16'h00AA, 4'd0, 0, 0, 0, 1, 1, 1, 0, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule